// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the main clock. Two dividers run in cascade. The first is a power-of-two prescaler chosen by a 2-bit select, and it divides by 2, 4, 8 or 16. The second is an even divider chosen by a 6-bit count field, and it divides the prescaled tick by 2*(count+1). Along with the serial clock, the block gives one-cycle strobes at each leading edge and each trailing edge, so that a shift engine can launch and capture data without having to detect edges itself.

The divider settings and the idle polarity are captured only while the block is disabled. When the enable is low, the serial clock rests at its idle level and both strobes stay quiet. A package function turns a wanted divide ratio (main clock rate over target rate) into a legal prescale select and count. It tries the prescale values upward from the smallest and clamps any request that falls outside the reachable range.

Top module: `spi_baud_gen`

## Requirements
- R1: With prescale select D (0..3) and count B, each half period of the serial clock lasts H = (B+1)*(2<<D) main-clock cycles. The first leading strobe appears H cycles after the first rising clock edge at which the enable is sampled high.
- R2: While enabled, the strobes alternate leading and trailing, one every H cycles.
- R3: A count field below 4 is captured as 4, so the smallest half period is 10 cycles.
- R4: When the leading strobe is high, the serial clock is at the opposite of the idle level. When the trailing strobe is high, it is back at the idle level. The two strobes are never high together.
- R5: While disabled, the serial clock settles at the idle level and both strobes stay low. Polarity 1 gives a high idle level and polarity 0 gives a low one.
- R6: Each strobe is high for exactly one main-clock cycle.
- R7: Changes to the prescale select, the count or the polarity while enabled do not affect the running clock. They take effect after the next disable and re-enable.
- R8: During reset, the serial clock is low and both strobes are low.
- R9: The helper function computes q = ratio/(4<<D) for D = 0, 1, 2, 3 in that order. It returns the first D with q <= 64, together with count q-1.
- R10: If q < 5 at D=0 (the rate is too high), the helper returns D=0 with count 4.
- R11: If no D gives q <= 64 (the rate is too low), the helper returns D=3 with count 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run the serial clock; low captures the configuration |
| div_sel_i | input | 2 | Prescale select D, divide by 2<<D |
| brg_i | input | 6 | Even-divider count B, half period of B+1 prescaled ticks |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe when the serial clock leaves idle |
| trail_o | output | 1 | One-cycle strobe when the serial clock returns to idle |

## Verification
A prescaler or count register that holds a wrong value shows up within the first half period after enable: the first leading strobe arrives at a cycle count other than (B+1)*(2<<D). Captured configuration that is corrupted mid-run changes the spacing between the next two strobes, so the error appears within one half period. A wrong idle level or a stray strobe is visible two cycles after the enable drops. Every helper corner (the first legal select, clamping at both ends, a zero ratio) is compared against values worked out by hand.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

   localparam int SB_DIV_W   = 2;
   localparam int SB_BRG_W   = 6;
   localparam int SB_BRG_MIN = 4;
   localparam int SB_BRG_MAX = (1 << SB_BRG_W) - 1;
   localparam int SB_DIV_MAX = (1 << SB_DIV_W) - 1;

   typedef struct packed {
      logic [SB_DIV_W-1:0] div;
      logic [SB_BRG_W-1:0] brg;
   } baud_cfg_t;

   // R9, R10, R11: choose the smallest prescale that gives a legal count.
   function automatic baud_cfg_t baud_from_ratio(input logic [31:0] ratio);
      baud_cfg_t   cfg;
      logic [31:0] q;
      logic        found;
      cfg.div = SB_DIV_W'(SB_DIV_MAX);
      cfg.brg = SB_BRG_W'(SB_BRG_MAX);
      found   = 1'b0;
      for (int d = 0; d <= SB_DIV_MAX; d++) begin
         if (!found) begin
            q = ratio >> (d + 2);
            if (q < 32'(SB_BRG_MIN + 1)) begin
               cfg.div = '0;
               cfg.brg = SB_BRG_W'(SB_BRG_MIN);
               found   = 1'b1;
            end else if (q <= 32'(SB_BRG_MAX + 1)) begin
               cfg.div = SB_DIV_W'(d);
               cfg.brg = SB_BRG_W'(q - 32'd1);
               found   = 1'b1;
            end
         end
      end
      return cfg;
   endfunction

endpackage

// File: rtl/spi_baud_cfgreg.sv
module spi_baud_cfgreg #(
   parameter int DIV_W     = 2,
   parameter int BRG_W     = 6,
   parameter int BRG_MIN   = 4,
   parameter bit CLAMP_BRG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_sel_i,
   input  logic [BRG_W-1:0] brg_i,
   input  logic             cpol_i,
   output logic [DIV_W-1:0] div_q,
   output logic [BRG_W-1:0] brg_q,
   output logic             cpol_q
);

   localparam logic [BRG_W-1:0] BRG_FLOOR = BRG_W'(BRG_MIN);

   logic [BRG_W-1:0] brg_legal;

   generate
      if (CLAMP_BRG) begin : g_clamp
         assign brg_legal = (brg_i < BRG_FLOOR) ? BRG_FLOOR : brg_i;
      end else begin : g_pass
         assign brg_legal = brg_i;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         div_q  <= '0;
         brg_q  <= BRG_FLOOR;
         cpol_q <= 1'b0;
      end else if (!en_i) begin
         div_q  <= div_sel_i;
         brg_q  <= brg_legal;
         cpol_q <= cpol_i;
      end
   end

   // R7: configuration frozen while running
   a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && $past(en_i)) |-> ($stable(div_q) && $stable(brg_q) && $stable(cpol_q)));

   // R3: captured count never below the floor
   a_r3_brg_floor: assert property (@(posedge clk_i) disable iff (rst_i)
      !CLAMP_BRG || (brg_q >= BRG_FLOOR));

endmodule

// File: rtl/spi_baud_prescale.sv
module spi_baud_prescale #(
   parameter int DIV_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_q,
   output logic             tick_o
);

   localparam int PRE_W = 1 << DIV_W;

   logic [PRE_W-1:0] cnt;
   logic [PRE_W-1:0] lim;

   // limit is (2 << div) - 1: div+1 ones from the bottom
   always_comb begin
      for (int i = 0; i < PRE_W; i++) begin
         lim[i] = (i <= int'(div_q));
      end
   end

   assign tick_o = en_i && (cnt == lim);

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i || cnt == lim) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R1: prescale counter stays inside its period
   a_r1_pre_range: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |-> (cnt <= lim));

endmodule

// File: rtl/spi_baud_divider.sv
module spi_baud_divider #(
   parameter int BRG_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [BRG_W-1:0] brg_q,
   output logic             toggle_o
);

   logic [BRG_W-1:0] cnt;

   assign toggle_o = tick_i && (cnt == brg_q);

   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i) begin
         cnt <= '0;
      end else if (tick_i) begin
         cnt <= (cnt == brg_q) ? '0 : cnt + 1'b1;
      end
   end

   // R1: tick count stays within brg+1 ticks
   a_r1_brg_range: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |-> (cnt <= brg_q));

endmodule

// File: rtl/spi_baud_edges.sv
module spi_baud_edges (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic toggle_i,
   input  logic cpol_q,
   output logic sclk_o,
   output logic lead_o,
   output logic trail_o
);

   logic at_idle;
   assign at_idle = (sclk_o == cpol_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sclk_o  <= 1'b0;
         lead_o  <= 1'b0;
         trail_o <= 1'b0;
      end else if (!en_i) begin
         sclk_o  <= cpol_q;
         lead_o  <= 1'b0;
         trail_o <= 1'b0;
      end else begin
         if (toggle_i) begin
            sclk_o <= ~sclk_o;
         end
         lead_o  <= toggle_i && at_idle;
         trail_o <= toggle_i && !at_idle;
      end
   end

   // R6: strobes last one cycle
   a_r6_lead_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
      lead_o |=> !lead_o);
   a_r6_trail_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
      trail_o |=> !trail_o);

   // R5: quiet when disabled
   a_r5_quiet_off: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (!lead_o && !trail_o));

   // R4: strobe levels and exclusivity
   a_r4_lead_level: assert property (@(posedge clk_i) disable iff (rst_i)
      lead_o |-> (sclk_o != cpol_q));
   a_r4_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
      !(lead_o && trail_o));

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int DIV_W     = spi_baud_pkg::SB_DIV_W,
   parameter int BRG_W     = spi_baud_pkg::SB_BRG_W,
   parameter int BRG_MIN   = spi_baud_pkg::SB_BRG_MIN,
   parameter bit CLAMP_BRG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_sel_i,
   input  logic [BRG_W-1:0] brg_i,
   input  logic             cpol_i,
   output logic             sclk_o,
   output logic             lead_o,
   output logic             trail_o
);

   generate
      if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
         $error("spi_baud_gen: DIV_W out of range");
      end
      if (BRG_MIN >= (1 << BRG_W)) begin : g_bad_brg
         $error("spi_baud_gen: BRG_MIN does not fit BRG_W");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [BRG_W-1:0] brg_q;
   logic             cpol_q;
   logic             tick;
   logic             toggle;

   spi_baud_cfgreg #(
      .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN), .CLAMP_BRG(CLAMP_BRG)
   ) u_cfg (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
      .div_sel_i(div_sel_i), .brg_i(brg_i), .cpol_i(cpol_i),
      .div_q(div_q), .brg_q(brg_q), .cpol_q(cpol_q)
   );

   spi_baud_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
      .div_q(div_q), .tick_o(tick)
   );

   spi_baud_divider #(.BRG_W(BRG_W)) u_div (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
      .tick_i(tick), .brg_q(brg_q), .toggle_o(toggle)
   );

   spi_baud_edges u_edge (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
      .toggle_i(toggle), .cpol_q(cpol_q),
      .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
   );

endmodule

// File: tb/spi_baud_gen_test.sv
`timescale 1ns/1ps
module spi_baud_gen_test;
   import spi_baud_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic [1:0] div_sel = 2'd0;
   logic [5:0] brg = 6'd4;
   logic       cpol = 1'b1;
   logic       sclk, lead, trail;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_baud_gen uut (
      .clk_i(clk), .rst_i(rst), .en_i(en), .div_sel_i(div_sel),
      .brg_i(brg), .cpol_i(cpol), .sclk_o(sclk), .lead_o(lead), .trail_o(trail)
   );

   // timing vectors: div, brg, cpol, expected half period
   localparam int NV = 8;
   localparam int VD[NV] = '{0, 1, 0, 2, 3, 0, 1, 3};
   localparam int VB[NV] = '{4, 4, 9, 5, 4, 63, 2, 63};
   localparam int VP[NV] = '{0, 1, 0, 1, 0, 1, 0, 1};
   localparam int VH[NV] = '{10, 20, 20, 48, 80, 128, 20, 1024};

   // helper vectors: ratio, expected div, expected brg
   localparam int NB = 8;
   localparam int BR[NB] = '{20, 10, 256, 260, 1000, 2048, 5000, 0};
   localparam int BD[NB] = '{0, 0, 0, 1, 2, 3, 3, 0};
   localparam int BB[NB] = '{4, 4, 63, 31, 61, 63, 63, 4};

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_strobe(input bit want_lead, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(want_lead ? lead : trail) && n < 5000);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      int h;
      baud_cfg_t c;

      // R8: reset state with polarity 1 requested
      repeat (3) @(negedge clk);
      chk(sclk == 1'b0, "R8 sclk in reset", int'(sclk), 0);
      chk(!lead && !trail, "R8 strobes in reset", int'(lead) + int'(trail), 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk(sclk == 1'b1, "R5 idle high cpol=1", int'(sclk), 1);

      // R9, R10, R11: helper function
      for (int i = 0; i < NB; i++) begin
         c = baud_from_ratio(32'(BR[i]));
         chk(int'(c.div) == BD[i], "R9/R10/R11 helper div", int'(c.div), BD[i]);
         chk(int'(c.brg) == BB[i], "R9/R10/R11 helper brg", int'(c.brg), BB[i]);
      end

      // R1, R2, R4, R5, R6 (R3 with brg=2): vector walk
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         en = 1'b0;
         div_sel = 2'(VD[v]);
         brg = 6'(VB[v]);
         cpol = VP[v][0];
         repeat (4) @(negedge clk);
         chk(sclk == cpol, "R5 idle level", int'(sclk), int'(cpol));
         en = 1'b1;
         wait_strobe(1'b1, n);
         chk(n == VH[v], "R1/R3 first lead delay", n, VH[v]);
         chk(sclk != cpol, "R4 level at lead", int'(sclk), int'(!cpol));
         chk(!trail, "R4 exclusive strobes", int'(trail), 0);
         @(negedge clk);
         chk(!lead, "R6 lead width", int'(lead), 0);
         wait_strobe(1'b0, n);
         chk(n == VH[v] - 1, "R2 lead to trail", n + 1, VH[v]);
         chk(sclk == cpol, "R4 level at trail", int'(sclk), int'(cpol));
         @(negedge clk);
         chk(!trail, "R6 trail width", int'(trail), 0);
         wait_strobe(1'b1, n);
         chk(n == VH[v] - 1, "R2 trail to lead", n + 1, VH[v]);
         en = 1'b0;
         repeat (2) @(negedge clk);
         chk(sclk == cpol && !lead && !trail, "R5 after disable", int'(sclk), int'(cpol));
      end

      // R5: no strobes while disabled, settings moving
      n = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         brg = 6'(4 + k);
         div_sel = 2'(k);
         if (lead || trail) n++;
      end
      chk(n == 0, "R5 no strobes while off", n, 0);
      cpol = 1'b0;
      repeat (3) @(negedge clk);
      chk(sclk == 1'b0, "R5 idle low cpol=0", int'(sclk), 0);

      // R7: changes while running ignored
      div_sel = 2'd0;
      brg = 6'd4;
      repeat (2) @(negedge clk);
      en = 1'b1;
      wait_strobe(1'b1, n);
      chk(n == 10, "R7 baseline lead", n, 10);
      div_sel = 2'd2;
      brg = 6'd20;
      cpol = 1'b1;
      wait_strobe(1'b0, n);
      chk(n == 10, "R7 spacing unchanged", n, 10);
      chk(sclk == 1'b0, "R7 polarity unchanged", int'(sclk), 0);
      en = 1'b0;
      repeat (3) @(negedge clk);
      chk(sclk == 1'b1, "R7 new polarity after disable", int'(sclk), 1);
      en = 1'b1;
      h = 21 * 8;
      wait_strobe(1'b1, n);
      chk(n == h, "R7 new setting after re-enable", n, h);
      chk(sclk == 1'b0, "R4 lead from high idle", int'(sclk), 0);
      en = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule